// File: doc/BRIEF.md
# CAM match priority encoder

This block sits behind the entry comparators of a content-addressable memory. Each entry raises one bit of an N-bit hit vector when its stored contents equal the search key. The block turns that vector into three results. The first is a binary index of the winning entry. The second is a flag saying that exactly one entry hit. The third is a flag saying that more than one entry hit. The lowest-numbered entry that hits always wins, so entry 0 has top priority. When both flags are low, no entry hit.

The encoder is combinational. A parameter can add one register stage on the outputs, for paths where the encoder would otherwise end a long timing chain. The entry count is a parameter. The index output is ceil(log2(N)) bits wide, and at least one bit. Entry storage, key comparison and write-address decoding belong to the surrounding CAM.

Top module: `cam_match_encoder`

## Requirements
- R1: When exactly one bit i of `matchVec` is set, `singleHit` is 1, `multiHit` is 0 and `matchAddr` equals i.
- R2: When two or more bits of `matchVec` are set, `multiHit` is 1, `singleHit` is 0 and `matchAddr` equals the index of the lowest-numbered set bit, since bit 0 has the highest priority.
- R3: `singleHit` and `multiHit` are never 1 in the same cycle.
- R4: When `matchVec` is all zero, `singleHit` and `multiHit` are both 0 and `matchAddr` is 0.
- R5: With `REGISTER_OUT` = 0, the outputs follow `matchVec` in the same cycle. With `REGISTER_OUT` = 1, they show the result for the `matchVec` value sampled at the previous rising edge of `clk`.
- R6: With `REGISTER_OUT` = 1, while `rstN` is 0 (active-low reset), all three outputs are 0 whatever `matchVec` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rstN | input | 1 | Active-low reset; clears the output register |
| matchVec | input | NUM_ENTRIES | Per-entry hit bits; bit i is high when entry i matches |
| matchAddr | output | max(1, ceil(log2(NUM_ENTRIES))) | Index of the lowest set bit, or 0 when no bit is set |
| singleHit | output | 1 | Exactly one bit of the vector is set |
| multiHit | output | 1 | Two or more bits of the vector are set |

## Verification
The bench builds two copies of the block.

The first copy has 8 entries and no output register. At that size all 256 hit vectors can be applied, so every priority case and every flag case is covered. These include the empty vector, each single bit, and every combination of several bits.

The second copy has 20 entries and the output register enabled. It shows that the index logic carries to a width that is not a power of two. Directed vectors cover the top and bottom entries and the all-ones vector, and random vectors fill in the rest. This copy also exercises the one-cycle latency and the reset clearing of the registered outputs.

// File: rtl/cam_enc_pkg.sv
package cam_enc_pkg;
  typedef struct packed {
    logic anyHit;
    logic manyHit;
  } hitStrobes_t;
endpackage

// File: rtl/cam_enc_ctrl.sv
module cam_enc_ctrl
  import cam_enc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] vecIn,
  output hitStrobes_t            strobes
);
  logic [NUM_ENTRIES-1:0] vecLowCleared;

  always_comb begin
    vecLowCleared   = vecIn & (vecIn - NUM_ENTRIES'(1));
    strobes.anyHit  = |vecIn;
    strobes.manyHit = |vecLowCleared;
  end

  AST_ONE_IS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(vecIn) == 1) |-> (strobes.anyHit && !strobes.manyHit)); // R1
  AST_MANY_IS_MULTI: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(vecIn) >= 2) |-> strobes.manyHit); // R2
  AST_NONE_IS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(vecIn) == 0) |-> (!strobes.anyHit && !strobes.manyHit)); // R4
endmodule

// File: rtl/cam_enc_dpath.sv
module cam_enc_dpath
  import cam_enc_pkg::*;
#(
  parameter int NUM_ENTRIES  = 16,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int AddrW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] vecIn,
  input  hitStrobes_t            strobes,
  output logic [AddrW-1:0]       addrOut,
  output logic                   singleOut,
  output logic                   multiOut
);
  logic [AddrW-1:0] addrComb;
  logic             singleComb;
  logic             multiComb;

  always_comb begin
    addrComb = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (vecIn[i]) addrComb = AddrW'(i);
    end
    singleComb = strobes.anyHit & ~strobes.manyHit;
    multiComb  = strobes.manyHit;
  end

  generate
    if (REGISTER_OUT) begin : gRegOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrOut   <= '0;
          singleOut <= 1'b0;
          multiOut  <= 1'b0;
        end else begin
          addrOut   <= addrComb;
          singleOut <= singleComb;
          multiOut  <= multiComb;
        end
      end
    end else begin : gCombOut
      always_comb begin
        addrOut   = addrComb;
        singleOut = singleComb;
        multiOut  = multiComb;
      end
    end
  endgenerate

  AST_ADDR_HITS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.anyHit |-> vecIn[addrComb]); // R1
  AST_ADDR_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.anyHit |-> ((vecIn & ((NUM_ENTRIES'(1) << addrComb) - NUM_ENTRIES'(1))) == '0)); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(singleOut && multiOut)); // R3
  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!singleOut && !multiOut) |-> (addrOut == '0)); // R4
endmodule

// File: rtl/cam_match_encoder.sv
module cam_match_encoder
  import cam_enc_pkg::*;
#(
  parameter int NUM_ENTRIES  = 16,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int AddrW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  output logic [AddrW-1:0]       matchAddr,
  output logic                   singleHit,
  output logic                   multiHit
);
  hitStrobes_t hitStrobes;

  cam_enc_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .vecIn   (matchVec),
    .strobes (hitStrobes)
  );

  cam_enc_dpath #(.NUM_ENTRIES(NUM_ENTRIES), .REGISTER_OUT(REGISTER_OUT)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .vecIn     (matchVec),
    .strobes   (hitStrobes),
    .addrOut   (matchAddr),
    .singleOut (singleHit),
    .multiOut  (multiHit)
  );
endmodule

// File: tb/test_cam_match_encoder.sv
`timescale 1ns/1ps
module test_cam_match_encoder;
  localparam int NarrowN = 8;
  localparam int WideN   = 20;
  localparam int NarrowW = $clog2(NarrowN);
  localparam int WideW   = $clog2(WideN);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NarrowN-1:0] vecA = '0;
  logic [WideN-1:0]   vecB = '0;
  logic [NarrowW-1:0] addrA;
  logic [WideW-1:0]   addrB;
  logic singleA, multiA, singleB, multiB;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cam_match_encoder #(.NUM_ENTRIES(NarrowN), .REGISTER_OUT(1'b0)) i_cam_match_encoder (
    .clk(clk), .rstN(rstN), .matchVec(vecA),
    .matchAddr(addrA), .singleHit(singleA), .multiHit(multiA)
  );

  cam_match_encoder #(.NUM_ENTRIES(WideN), .REGISTER_OUT(1'b1)) i_cam_match_encoder_wide (
    .clk(clk), .rstN(rstN), .matchVec(vecB),
    .matchAddr(addrB), .singleHit(singleB), .multiHit(multiB)
  );

  task automatic refModel(input logic [31:0] v, input int n,
                          output int addr, output bit s, output bit m);
    int cnt = 0;
    addr = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) begin
        addr = i;
        cnt++;
      end
    end
    s = (cnt == 1);
    m = (cnt >= 2);
  endtask

  function automatic string tagFor(bit s, bit m);
    if (s) return "R1";
    if (m) return "R2";
    return "R4";
  endfunction

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOut(input string ctx, input logic [31:0] v, input int n,
                          input int aAct, input bit sAct, input bit mAct);
    int ea;
    bit es, em;
    string t;
    refModel(v, n, ea, es, em);
    t = tagFor(es, em);
    checkVal({t, " ", ctx}, "addr", aAct, ea);
    checkVal({t, " ", ctx}, "single", int'(sAct), int'(es));
    checkVal({t, " ", ctx}, "multi", int'(mAct), int'(em));
    checkVal({"R3 ", ctx}, "both flags", int'(sAct & mAct), 0);
  endtask

  logic [WideN-1:0] prevB;
  bit prevValid = 1'b0;

  task automatic stepWide(input logic [WideN-1:0] nv);
    @(negedge clk);
    if (prevValid) checkOut("R5 wide", 32'(prevB), WideN, int'(addrB), singleB, multiB);
    vecB = nv;
    prevB = nv;
    prevValid = 1'b1;
  endtask

  initial begin
    vecB = '1;
    vecA = 8'h06;
    repeat (3) @(negedge clk);
    checkVal("R6", "reset addr", int'(addrB), 0);
    checkVal("R6", "reset single", int'(singleB), 0);
    checkVal("R6", "reset multi", int'(multiB), 0);
    rstN = 1'b1;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      vecA = 8'(v);
      #1;
      checkOut("R5 narrow", 32'(v), NarrowN, int'(addrA), singleA, multiA);
    end
    stepWide('0);
    stepWide(20'h80000);
    stepWide(20'h00001);
    stepWide('1);
    stepWide(20'h80001);
    stepWide(20'h00000);
    for (int k = 0; k < WideN; k++) stepWide(WideN'(1) << k);
    for (int k = 0; k < 400; k++) stepWide(WideN'($urandom));
    for (int k = 0; k < 100; k++) stepWide(WideN'($urandom) & WideN'($urandom) & WideN'($urandom));
    stepWide('0);
    stepWide('0);
    vecB = 20'h00400;
    rstN = 1'b0;
    #1;
    checkVal("R6", "async reset single", int'(singleB), 0);
    @(negedge clk);
    checkVal("R6", "held reset addr", int'(addrB), 0);
    checkVal("R6", "held reset single", int'(singleB), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule